// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind a two-wire serial target engine in a small non-volatile memory. It collects the data bytes of one write transfer in a page-wide latch and records which lanes hold a byte. When the transfer ends, it hands all of them to the storage array in a single masked page write. The target engine loads the starting word address, pushes data bytes one at a time and signals the end of the transfer. The block then commits the latched bytes and holds a busy flag for a fixed self-timed programming window. The target engine uses that flag to refuse acknowledges.

The word address splits into a page number (the upper bits) and an in-page index (the low bits). Only the index advances as bytes arrive, so a transfer never leaves its page. It wraps to lane zero and overwrites earlier lanes instead. A hardware protect input, sampled when the transfer ends, blocks the commit for the whole array. A transfer that carries no data bytes, such as one that only sets the pointer before a read, starts no programming window.

Top module: `pwb_engine`

## Requirements
- R1: While reset is high and in the cycle after it, busy, arr_we and arr_mask are all zero.
- R2: A byte pushed after an address load lands in lane addr[3:0] of page addr[10:4]. Each further byte goes to the next lane. arr_data lane i occupies bits [8*i+7:8*i], and bit i of arr_mask is set exactly for lanes written in the transfer.
- R3: When more than 16 bytes arrive in one transfer, the lane index wraps from 15 to 0 and the later byte replaces the earlier one in that lane.
- R4: A start address that is not a multiple of 16 wraps back to lane 0 of the same page. arr_page always equals the loaded addr[10:4].
- R5: No array write happens before the end-of-transfer strobe. After an accepted stop with data, arr_we is high for exactly one cycle, in the cycle that follows the stop.
- R6: busy rises in the same cycle as arr_we and stays high for exactly BUSY_CYCLES cycles.
- R7: If wr_protect is high at the stop, no array write takes place and busy stays low. The latched bytes are discarded.
- R8: A stop with no bytes latched since the last address load or stop produces no array write and leaves busy low.
- R9: While busy is high, address loads, byte pushes and stops are ignored. A stop issued after the window therefore finds no latched bytes.
- R10: A byte pushed in the same cycle as the stop is part of the commit.
- R11: An address load discards the bytes latched before it, so only bytes pushed after the latest load are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load start word address strobe |
| addr_in | input | 11 | Start word address |
| byte_push | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| xfer_stop | input | 1 | End-of-transfer strobe |
| wr_protect | input | 1 | Hardware write protect |
| busy | output | 1 | Self-timed programming window active |
| arr_we | output | 1 | Array page write strobe |
| arr_page | output | 7 | Target page number |
| arr_data | output | 128 | Page data, lane i in bits 8*i+7 down to 8*i |
| arr_mask | output | 16 | Per-lane byte enable |

## Verification
A byte push and the end-of-transfer strobe can fall in the same clock cycle. The design must then latch the byte and commit it together with the rest of the page. The bench provokes this on purpose in a directed case, and randomly in about half of the random transfers by raising the final push and the stop together. It judges the result by checking that the final byte's lane is set in arr_mask and carries that byte in arr_data. Address load followed by pushes to a different page is also exercised, so that stale lanes from the previous pointer would show up in the mask.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // one-hot lane select for a given index
  function automatic logic [63:0] lane_sel(input int unsigned idx);
    logic [63:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    adv,
  output logic [ADDR_W-IDX_W-1:0] page_cur,
  output logic [IDX_W-1:0]        idx_cur
);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;

  // a load in this cycle takes effect for a push in the same cycle
  always_comb begin
    page_cur = load ? addr_in[ADDR_W-1:IDX_W] : page_q;
    idx_cur  = load ? addr_in[IDX_W-1:0]      : idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      idx_q  <= '0;
    end else begin
      page_q <= page_cur;
      idx_q  <= idx_cur + IDX_W'(adv);  // wraps inside the page
    end
  end
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int LANES  = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_pre,
  input  logic                    wr,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr_post,
  output logic [LANES*DATA_W-1:0] data_cur,
  output logic [LANES-1:0]        valid_cur
);
  logic [DATA_W-1:0] mem [LANES];
  logic [LANES-1:0]  vld_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = wr && (wr_idx == IDX_W'(i));
    assign data_cur[i*DATA_W +: DATA_W] = hit ? wr_data : mem[i];
    assign valid_cur[i] = hit | (vld_q[i] & ~clr_pre);
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)           vld_q <= '0;
    else if (clr_post) vld_q <= '0;
    else               vld_q <= valid_cur;
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int CYCLES = 1000,
  parameter int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwb_engine.sv
module pwb_engine #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  addr_load,
  input  logic [ADDR_W-1:0]                     addr_in,
  input  logic                                  byte_push,
  input  logic [DATA_W-1:0]                     byte_data,
  input  logic                                  xfer_stop,
  input  logic                                  wr_protect,
  output logic                                  busy,
  output logic                                  arr_we,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  arr_page,
  output logic [PAGE_BYTES*DATA_W-1:0]          arr_data,
  output logic [PAGE_BYTES-1:0]                 arr_mask
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int LINE_W = PAGE_BYTES * DATA_W;

  logic              load_ok, push_ok, stop_ok, commit_go;
  logic [PAGE_W-1:0] page_cur;
  logic [IDX_W-1:0]  idx_cur;
  logic [LINE_W-1:0] data_cur;
  logic [PAGE_BYTES-1:0] valid_cur;

  // strobes are refused for the whole programming window
  assign load_ok = addr_load & ~busy;
  assign push_ok = byte_push & ~busy;
  assign stop_ok = xfer_stop & ~busy;
  assign commit_go = stop_ok & (|valid_cur) & ~wr_protect;

  pwb_pointer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .load(load_ok), .addr_in(addr_in),
    .adv(push_ok), .page_cur(page_cur), .idx_cur(idx_cur)
  );

  pwb_latch #(.LANES(PAGE_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lat (
    .clk(clk), .rst(rst), .clr_pre(load_ok), .wr(push_ok),
    .wr_idx(idx_cur), .wr_data(byte_data), .clr_post(stop_ok),
    .data_cur(data_cur), .valid_cur(valid_cur)
  );

  pwb_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(commit_go), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we   <= 1'b0;
      arr_page <= '0;
      arr_data <= '0;
      arr_mask <= '0;
    end else begin
      arr_we <= commit_go;
      if (commit_go) begin
        arr_page <= page_cur;
        arr_data <= data_cur;
        arr_mask <= valid_cur;
      end else begin
        arr_mask <= '0;
      end
    end
  end
endmodule

// File: rtl/pwb_engine_chk.sv
module pwb_engine_chk #(
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  arr_we,
  input logic [PAGE_BYTES-1:0] arr_mask,
  input logic                  xfer_stop,
  input logic                  wr_protect
);
  int unsigned blen;

  always_ff @(posedge clk) begin
    if (rst)       blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!busy && !arr_we));
  p_mask_r2: assert property (@(posedge clk) disable iff (rst) arr_we |-> (arr_mask != '0));
  p_pulse_r5: assert property (@(posedge clk) disable iff (rst) arr_we |=> !arr_we);
  p_we_busy_r6: assert property (@(posedge clk) disable iff (rst) arr_we |-> busy);
  p_rise_r6: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> arr_we);
  p_len_r6: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (blen == BUSY_CYCLES));
  p_protect_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_stop && wr_protect && !busy) |=> !arr_we);
endmodule

bind pwb_engine pwb_engine_chk #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .arr_we(arr_we), .arr_mask(arr_mask),
  .xfer_stop(xfer_stop), .wr_protect(wr_protect)
);

// File: tb/pwb_engine_bench.sv
module pwb_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 20;

  logic clk = 0, rst = 1;
  logic addr_load = 0, byte_push = 0, xfer_stop = 0, wr_protect = 0;
  logic [10:0] addr_in = '0;
  logic [7:0] byte_data = '0;
  logic busy, arr_we;
  logic [6:0] arr_page;
  logic [127:0] arr_data;
  logic [15:0] arr_mask;

  int checks = 0, errors = 0;

  logic [7:0]  exp_data [16];
  logic [15:0] exp_valid;
  logic [3:0]  exp_idx;
  logic [6:0]  exp_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_engine #(.BUSY_CYCLES(BUSY)) u_pwb_engine (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_push(byte_push), .byte_data(byte_data), .xfer_stop(xfer_stop),
    .wr_protect(wr_protect), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
    .arr_data(arr_data), .arr_mask(arr_mask)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [127:0] exp_line();
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) if (exp_valid[i]) v[8*i +: 8] = exp_data[i];
    return v;
  endfunction

  function automatic logic [127:0] masked(input logic [127:0] d, input logic [15:0] m);
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) if (m[i]) v[8*i +: 8] = d[8*i +: 8];
    return v;
  endfunction

  task automatic do_load(input logic [10:0] a);
    addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
    exp_page = a[10:4]; exp_idx = a[3:0]; exp_valid = '0;
  endtask

  task automatic model_push(input logic [7:0] d);
    exp_data[exp_idx] = d; exp_valid[exp_idx] = 1'b1; exp_idx = exp_idx + 4'd1;
  endtask

  task automatic do_push(input logic [7:0] d);
    byte_push = 1; byte_data = d;
    @(negedge clk); byte_push = 0;
    model_push(d);
    chk(arr_we == 0, "R5 no write before stop", {127'd0, arr_we}, 128'd0);
  endtask

  // stop, optionally with a final byte in the same cycle; check the commit
  task automatic start_commit(input bit wp, input bit merge, input logic [7:0] d, input string tag);
    bit expect_we;
    xfer_stop = 1; wr_protect = wp;
    if (merge) begin byte_push = 1; byte_data = d; model_push(d); end
    @(negedge clk);
    xfer_stop = 0; wr_protect = 0; byte_push = 0;
    expect_we = (exp_valid != 0) && !wp;
    chk(arr_we == expect_we, {tag, " write strobe"}, {127'd0, arr_we}, {127'd0, expect_we});
    if (expect_we) begin
      chk(arr_mask == exp_valid, {tag, " R2 mask"}, {112'd0, arr_mask}, {112'd0, exp_valid});
      chk(arr_page == exp_page, {tag, " R4 page"}, {121'd0, arr_page}, {121'd0, exp_page});
      chk(masked(arr_data, exp_valid) == exp_line(), {tag, " R2 data"}, masked(arr_data, exp_valid), exp_line());
    end
    exp_valid = '0;
  endtask

  task automatic wait_busy(input int expn, input string tag);
    int n = 0;
    while (busy && n < BUSY + 5) begin n++; @(negedge clk); end
    chk(n == expn, {tag, " R6 busy length"}, 128'(n), 128'(expn));
  endtask

  task automatic finish_xfer(input bit wp, input bit merge, input logic [7:0] d, input string tag);
    bit expect_we;
    expect_we = ((exp_valid != 0) || merge) && !wp;
    start_commit(wp, merge, d, tag);
    wait_busy(expect_we ? BUSY : 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    exp_valid = '0; exp_idx = '0; exp_page = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && arr_we == 0 && arr_mask == 0, "R1 reset state", {111'd0, busy, arr_we, arr_mask}, 128'd0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && arr_we == 0 && arr_mask == 0, "R1 after reset", {111'd0, busy, arr_we, arr_mask}, 128'd0);

    // R2: aligned, three bytes
    do_load(11'h230);
    do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
    finish_xfer(0, 0, 8'h00, "R2 aligned");

    // R3: 20 bytes wrap and overwrite lanes 0..3
    do_load(11'h040);
    for (int i = 0; i < 20; i++) do_push(8'(8'h10 + i));
    finish_xfer(0, 0, 8'h00, "R3 overflow");

    // R4: unaligned start wraps inside the page
    do_load(11'h1AE);
    for (int i = 0; i < 5; i++) do_push(8'(8'h50 + i));
    finish_xfer(0, 0, 8'h00, "R4 unaligned");

    // R7: protected stop, then empty stop finds nothing
    do_load(11'h300);
    do_push(8'h77); do_push(8'h88);
    finish_xfer(1, 0, 8'h00, "R7 protect");
    finish_xfer(0, 0, 8'h00, "R7 discarded");

    // R8: address-only transfer
    do_load(11'h123);
    finish_xfer(0, 0, 8'h00, "R8 empty stop");

    // R10: push with stop in the same cycle
    do_load(11'h4F8);
    do_push(8'h01);
    finish_xfer(0, 1, 8'hEE, "R10 push with stop");

    // R11: reload discards earlier bytes
    do_load(11'h600);
    do_push(8'h99); do_push(8'h98);
    do_load(11'h615);
    do_push(8'h31); do_push(8'h32);
    finish_xfer(0, 0, 8'h00, "R11 reload");

    // R9: strobes during busy are ignored
    do_load(11'h700);
    do_push(8'h44);
    start_commit(0, 0, 8'h00, "R9 commit");
    addr_load = 1; addr_in = 11'h010; @(negedge clk); addr_load = 0;
    byte_push = 1; byte_data = 8'h66; @(negedge clk); byte_push = 0;
    xfer_stop = 1; @(negedge clk); xfer_stop = 0;
    chk(arr_we == 0, "R9 stop ignored while busy", {127'd0, arr_we}, 128'd0);
    wait_busy(BUSY - 3, "R9");
    finish_xfer(0, 0, 8'h00, "R9 after window");

    // random transfers
    for (int t = 0; t < 40; t++) begin
      logic [10:0] a;
      int n;
      bit wp, merge;
      a = 11'($urandom % 2048);
      n = 1 + int'($urandom % 40);
      wp = ($urandom % 8) == 0;
      merge = ($urandom % 2) == 1;
      do_load(a);
      for (int k = 0; k < n - (merge ? 1 : 0); k++) do_push(8'($urandom));
      finish_xfer(wp, merge, 8'($urandom), "R2 R3 R4 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule